// File: doc/BRIEF.md
# Masked Key-Class Permission Register

This block guards the memory accesses of one accelerator slice. Storage pages carry a 5-bit protection key that names one of 32 classes. For each class, a 64-bit authority mask holds one bit that blocks writes and one bit that blocks reads. Each access request presents the page key and a read/write flag, and the block answers with permit or deny. The answer is available combinationally, and a registered copy follows one cycle after the request.

Two privileged stores program the block, each a full 64-bit write. A store to the override mask loads it directly. A store to the authority mask changes only the bits that the override mask allows, and keeps every other bit at its old value. A context load builds an effective mask by the same merge from a per-process mask. The effective mask goes into a shadow register that checks can use when the select input is high. It is never written back to the visible authority register. Clearing the select input discards the shadow.

Top module: `key_perm_reg`

## Requirements
- R1: After reset both the authority register and the override register read zero, and every class permits both reads and writes.
- R2: When `ovr_wr_en` is high, `ovr_q` holds `wr_data` from the next cycle on.
- R3: When `auth_wr_en` is high, `auth_q` becomes `(auth_q & ~ovr_q) | (wr_data & ovr_q)` in the next cycle. The override value used is the one held before that edge, so an override store in the same cycle acts only on later stores.
- R4: Authority bits whose override bit is 0 are never changed by a store. With `ovr_q` all zero, an authority store leaves `auth_q` unchanged.
- R5: A context load (`ctx_load` high) captures `(auth_q & ~ovr_q) | (ctx_mask & ovr_q)` into the shadow, and does not change `auth_q` or `ovr_q`.
- R6: Checks use the shadow only while `use_eff` is high and a context load has happened since `use_eff` was last low. Otherwise they use `auth_q`. A cycle with `use_eff` low and no context load discards the shadow.
- R7: Bits are numbered MSB-first, so bit 0 is vector index 63. For class x, bit 2x (vector index 63-2x) blocks writes and bit 2x+1 (vector index 62-2x) blocks reads. A 1 denies and a 0 permits.
- R8: `acc_deny` follows the key, the flag and the active mask combinationally. `acc_deny_q` equals the `acc_deny` of the previous cycle when `acc_req` was high in that cycle, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ovr_wr_en | input | 1 | Store strobe for the override mask |
| auth_wr_en | input | 1 | Store strobe for the authority mask (merged) |
| wr_data | input | 64 | Store data |
| ctx_load | input | 1 | Context-load strobe, fills the shadow effective mask |
| ctx_mask | input | 64 | Per-process mask for the context load |
| use_eff | input | 1 | Select the shadow effective mask for checks |
| acc_req | input | 1 | Access request valid |
| acc_key | input | 5 | Protection key of the accessed page |
| acc_is_rd | input | 1 | 1 = read, 0 = write |
| acc_deny | output | 1 | Combinational deny for the current key and flag |
| acc_deny_q | output | 1 | Registered deny, one cycle after a request |
| auth_q | output | 64 | Stored authority mask (register read) |
| ovr_q | output | 64 | Stored override mask (register read) |

## Verification
The bench builds the block with its defaults: 32 classes, which gives a 5-bit key and 64-bit masks. At this size all 64 bit positions can be reached, including both ends of the MSB-first numbering (class 0 writes at index 63, class 31 reads at index 0). Random override masks with mixed density exercise the merge on both kept bits and replaced bits. Random toggling of `use_eff` and `ctx_load` reaches every state of the shadow: valid, discarded, and reloaded in the same cycle as a clear.

// File: rtl/kpr_pkg.sv
package kpr_pkg;
  // Access direction carried with each request
  typedef enum logic {
    ACC_WR = 1'b0,
    ACC_RD = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/kpr_rst_sync.sv
module kpr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/kpr_mask_regs.sv
module kpr_mask_regs #(
  parameter int MASK_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovr_wr_en,
  input  logic              auth_wr_en,
  input  logic [MASK_W-1:0] wr_data,
  output logic [MASK_W-1:0] auth_q,
  output logic [MASK_W-1:0] ovr_q
);
  logic [MASK_W-1:0] auth_d;
  logic [MASK_W-1:0] ovr_d;

  always_comb begin
    ovr_d  = ovr_q;
    auth_d = auth_q;
    if (ovr_wr_en)  ovr_d  = wr_data;
    // merge uses the override held before this edge
    if (auth_wr_en) auth_d = (auth_q & ~ovr_q) | (wr_data & ovr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auth_q <= '0;
      ovr_q  <= '0;
    end else begin
      if (ovr_wr_en)  ovr_q  <= ovr_d;
      if (auth_wr_en) auth_q <= auth_d;
    end
  end
endmodule

// File: rtl/kpr_shadow.sv
module kpr_shadow #(
  parameter int MASK_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctx_load,
  input  logic [MASK_W-1:0] ctx_mask,
  input  logic              use_eff,
  input  logic [MASK_W-1:0] auth_q,
  input  logic [MASK_W-1:0] ovr_q,
  output logic [MASK_W-1:0] eff_q,
  output logic              eff_vld_q
);
  logic [MASK_W-1:0] eff_d;
  logic              vld_d;

  always_comb begin
    eff_d = (auth_q & ~ovr_q) | (ctx_mask & ovr_q);
    if (ctx_load)     vld_d = 1'b1;
    else if (use_eff) vld_d = eff_vld_q;
    else              vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q     <= '0;
      eff_vld_q <= 1'b0;
    end else begin
      if (ctx_load) eff_q <= eff_d;
      eff_vld_q <= vld_d;
    end
  end
endmodule

// File: rtl/kpr_lookup.sv
module kpr_lookup #(
  parameter int NUM_CLASS = 32,
  localparam int MASK_W   = 2 * NUM_CLASS,
  localparam int KEY_W    = $clog2(NUM_CLASS)
) (
  input  logic [MASK_W-1:0] mask,
  input  logic [KEY_W-1:0]  key,
  input  kpr_pkg::acc_kind_e kind,
  output logic              deny
);
  logic [NUM_CLASS-1:0] wr_blk;
  logic [NUM_CLASS-1:0] rd_blk;

  // MSB-first numbering: class c write bit at 2c, read bit at 2c+1
  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
    assign wr_blk[c] = mask[MASK_W-1-2*c];
    assign rd_blk[c] = mask[MASK_W-2-2*c];
  end

  assign deny = (kind == kpr_pkg::ACC_RD) ? rd_blk[key] : wr_blk[key];
endmodule

// File: rtl/key_perm_reg.sv
module key_perm_reg #(
  parameter int NUM_CLASS = 32,
  localparam int MASK_W   = 2 * NUM_CLASS,
  localparam int KEY_W    = $clog2(NUM_CLASS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovr_wr_en,
  input  logic              auth_wr_en,
  input  logic [MASK_W-1:0] wr_data,
  input  logic              ctx_load,
  input  logic [MASK_W-1:0] ctx_mask,
  input  logic              use_eff,
  input  logic              acc_req,
  input  logic [KEY_W-1:0]  acc_key,
  input  logic              acc_is_rd,
  output logic              acc_deny,
  output logic              acc_deny_q,
  output logic [MASK_W-1:0] auth_q,
  output logic [MASK_W-1:0] ovr_q
);
  logic              rst_sync_n;
  logic [MASK_W-1:0] eff_q;
  logic              eff_vld_q;
  logic [MASK_W-1:0] act_mask;
  logic              deny_d;
  kpr_pkg::acc_kind_e kind;

  kpr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  kpr_mask_regs #(.MASK_W(MASK_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ovr_wr_en  (ovr_wr_en),
    .auth_wr_en (auth_wr_en),
    .wr_data    (wr_data),
    .auth_q     (auth_q),
    .ovr_q      (ovr_q)
  );

  kpr_shadow #(.MASK_W(MASK_W)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctx_load  (ctx_load),
    .ctx_mask  (ctx_mask),
    .use_eff   (use_eff),
    .auth_q    (auth_q),
    .ovr_q     (ovr_q),
    .eff_q     (eff_q),
    .eff_vld_q (eff_vld_q)
  );

  assign act_mask = (use_eff && eff_vld_q) ? eff_q : auth_q;
  assign kind     = acc_is_rd ? kpr_pkg::ACC_RD : kpr_pkg::ACC_WR;

  kpr_lookup #(.NUM_CLASS(NUM_CLASS)) u_lookup (
    .mask (act_mask),
    .key  (acc_key),
    .kind (kind),
    .deny (acc_deny)
  );

  always_comb deny_d = acc_req & acc_deny;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) acc_deny_q <= 1'b0;
    else             acc_deny_q <= deny_d;
  end
endmodule

// File: rtl/kpr_checker.sv
module kpr_checker #(
  parameter int MASK_W = 64
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              ovr_wr_en,
  input logic              auth_wr_en,
  input logic [MASK_W-1:0] wr_data,
  input logic              ctx_load,
  input logic              use_eff,
  input logic              acc_req,
  input logic              acc_deny,
  input logic              acc_deny_q,
  input logic [MASK_W-1:0] auth_q,
  input logic [MASK_W-1:0] ovr_q,
  input logic [MASK_W-1:0] act_mask
);
  p_ovr_load_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    ovr_wr_en |=> (ovr_q == $past(wr_data)));

  p_auth_merge_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    auth_wr_en |=> (auth_q == (($past(auth_q) & ~$past(ovr_q)) | ($past(wr_data) & $past(ovr_q)))));

  p_locked_bits_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |=> ((auth_q & ~$past(ovr_q)) == ($past(auth_q) & ~$past(ovr_q))));

  p_ctx_no_wb_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (ctx_load && !auth_wr_en) |=> $stable(auth_q));

  p_shadow_drop_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (!use_eff && !ctx_load) |=> (act_mask == auth_q));

  p_deny_reg_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |=> (acc_deny_q == ($past(acc_req) && $past(acc_deny))));
endmodule

bind key_perm_reg kpr_checker #(.MASK_W(MASK_W)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .ovr_wr_en  (ovr_wr_en),
  .auth_wr_en (auth_wr_en),
  .wr_data    (wr_data),
  .ctx_load   (ctx_load),
  .use_eff    (use_eff),
  .acc_req    (acc_req),
  .acc_deny   (acc_deny),
  .acc_deny_q (acc_deny_q),
  .auth_q     (auth_q),
  .ovr_q      (ovr_q),
  .act_mask   (act_mask)
);

// File: tb/sim_key_perm_reg.sv
`timescale 1ns/1ps
module sim_key_perm_reg;
  localparam int NC = 32;
  localparam int MW = 2 * NC;
  localparam int KW = $clog2(NC);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ovr_wr_en, auth_wr_en, ctx_load, use_eff, acc_req, acc_is_rd;
  logic [MW-1:0] wr_data, ctx_mask;
  logic [KW-1:0] acc_key;
  logic          acc_deny, acc_deny_q;
  logic [MW-1:0] auth_q, ovr_q;

  int n_chk = 0;
  int n_err = 0;

  // model state
  logic [MW-1:0] m_auth, m_ovr, m_eff;
  logic          m_vld, m_dq;

  always #2.5 clk = ~clk;

  key_perm_reg #(.NUM_CLASS(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .ovr_wr_en(ovr_wr_en), .auth_wr_en(auth_wr_en),
    .wr_data(wr_data), .ctx_load(ctx_load), .ctx_mask(ctx_mask), .use_eff(use_eff),
    .acc_req(acc_req), .acc_key(acc_key), .acc_is_rd(acc_is_rd),
    .acc_deny(acc_deny), .acc_deny_q(acc_deny_q), .auth_q(auth_q), .ovr_q(ovr_q)
  );

  function automatic logic [MW-1:0] merge(logic [MW-1:0] old, logic [MW-1:0] nw, logic [MW-1:0] ov);
    return (old & ~ov) | (nw & ov);
  endfunction

  // R7: MSB-first numbering, write bit 2x, read bit 2x+1
  function automatic logic exp_deny(logic [MW-1:0] m, logic [KW-1:0] k, logic rd);
    int pos;
    pos = 2 * int'(k) + (rd ? 1 : 0);
    return m[MW-1-pos];
  endfunction

  function automatic logic [MW-1:0] act();
    return (use_eff && m_vld) ? m_eff : m_auth;
  endfunction

  task automatic chk(string tag, logic [MW-1:0] got, logic [MW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    ovr_wr_en = 0; auth_wr_en = 0; ctx_load = 0; acc_req = 0;
  endtask

  // advance one edge, update model, then check registered state and comb deny
  task automatic tick(string tag);
    logic [MW-1:0] na, no, ne;
    logic nv, nd;
    @(posedge clk);
    nd = acc_req && exp_deny(act(), acc_key, acc_is_rd);
    na = auth_wr_en ? merge(m_auth, wr_data, m_ovr) : m_auth;
    no = ovr_wr_en ? wr_data : m_ovr;
    ne = ctx_load ? merge(m_auth, ctx_mask, m_ovr) : m_eff;
    nv = ctx_load ? 1'b1 : (use_eff ? m_vld : 1'b0);
    m_auth = na; m_ovr = no; m_eff = ne; m_vld = nv; m_dq = nd;
    #1;
    chk({tag, " auth_q"}, auth_q, m_auth);
    chk({tag, " ovr_q"}, ovr_q, m_ovr);
    chk({tag, " R8 deny_q"}, MW'(acc_deny_q), MW'(m_dq));
    chk({tag, " R8 deny"}, MW'(acc_deny), MW'(exp_deny(act(), acc_key, acc_is_rd)));
  endtask

  initial begin
    #200000;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    idle(); use_eff = 0; wr_data = '0; ctx_mask = '0; acc_key = '0; acc_is_rd = 0;
    m_auth = '0; m_ovr = '0; m_eff = '0; m_vld = 0; m_dq = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 auth reset", auth_q, '0);
    chk("R1 ovr reset", ovr_q, '0);
    acc_req = 1; acc_key = 5'd31; acc_is_rd = 1; #1;
    chk("R1 permit after reset", MW'(acc_deny), '0);
    idle();

    // R4: override zero blocks authority store
    auth_wr_en = 1; wr_data = '1; tick("R4");
    idle(); #1 chk("R4 auth unchanged", auth_q, '0);

    // R2: override load, R3: merge
    ovr_wr_en = 1; wr_data = 64'hFF00_FF00_0000_FFFF; tick("R2");
    idle(); auth_wr_en = 1; wr_data = 64'hA5A5_A5A5_A5A5_A5A5; tick("R3");
    chk("R3 merged", auth_q, 64'hA500_A500_0000_A5A5);
    // R3: same-cycle override store acts on later stores only
    idle(); ovr_wr_en = 1; auth_wr_en = 1; wr_data = '1; tick("R3 same-cycle");
    chk("R3 old override used", auth_q, 64'hFF00_FF00_0000_FFFF);

    // R7: class 0 write bit at index 63, class 31 read bit at index 0
    idle(); ovr_wr_en = 1; wr_data = '1; tick("R2");
    idle(); auth_wr_en = 1; wr_data = 64'h8000_0000_0000_0001; tick("R7 setup");
    idle(); acc_req = 1; acc_key = 0; acc_is_rd = 0; tick("R7 class0 wr");
    chk("R7 class0 write denied", MW'(acc_deny), 64'd1);
    acc_is_rd = 1; #1 chk("R7 class0 read permitted", MW'(acc_deny), '0);
    acc_key = 5'd31; #1 chk("R7 class31 read denied", MW'(acc_deny), 64'd1);
    acc_is_rd = 0; #1 chk("R7 class31 write permitted", MW'(acc_deny), '0);

    // R5/R6: context load into shadow, no write back, drop on deselect
    idle(); ctx_load = 1; ctx_mask = 64'h4000_0000_0000_0000; use_eff = 1; tick("R5");
    chk("R5 auth kept", auth_q, 64'h8000_0000_0000_0001);
    idle(); acc_req = 1; acc_key = 0; acc_is_rd = 1; #1;
    chk("R6 shadow read deny", MW'(acc_deny), 64'd1);
    use_eff = 0; #1 chk("R6 deselect uses auth", MW'(acc_deny), '0);
    tick("R6 drop"); use_eff = 1; #1;
    chk("R6 shadow discarded", MW'(acc_deny), '0);
    acc_req = 0; tick("R8 no req");
    chk("R8 deny_q low", MW'(acc_deny_q), '0);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      ovr_wr_en  = (r < 8);
      auth_wr_en = ($urandom_range(0, 99) < 25);
      ctx_load   = ($urandom_range(0, 99) < 10);
      use_eff    = ($urandom_range(0, 99) < 60);
      acc_req    = ($urandom_range(0, 99) < 70);
      acc_key    = KW'($urandom);
      acc_is_rd  = 1'($urandom);
      wr_data    = {$urandom, $urandom};
      if (r < 3) wr_data = '0;
      ctx_mask   = {$urandom, $urandom};
      tick("R2/R3/R5/R6/R8 random");
    end

    idle();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule